// File: doc/BRIEF.md
# Three-wire identity-framed serial slave

This block is the serial control port of an audio control chip. It listens on three lines driven by a controller: a bus clock, an identity line and a shared data line that either side can pull low. It runs on a fast system clock, so all bus lines and the two auxiliary status inputs first pass through multi-flop synchronizers. Edges of the bus clock are then found in the system clock domain.

A transfer starts when the controller pulls both the clock and the identity line low. While identity stays low, bits are shifted in on rising bus clock edges, most significant bit first. When identity returns high, the last eight bits received are taken as the address byte. The block answers only the eight addresses from 0x40 to 0x47. The low three address bits pick one of eight functions. With identity high, the controller then clocks eight value bits. The transfer ends with a low pulse on identity that lasts at least a parameter-set number of system cycles. Only at that point does the block present the function index and value byte, together with a one-cycle write strobe. Address 0x47 is a read instead of a write. During its value phase the block returns the two auxiliary inputs on the data line, in open-drain fashion, and it issues no write strobe for it.

Top module: `idsel_serial_slave`

## Requirements
- R1: After reset, `wr_strobe_o` is 0, `func_o` is 0, `value_o` is 0 and `bus_data_oe_o` is 0 (data line released).
- R2: A transfer has three parts: an address byte sent with identity low, eight value bits sent with identity high, and a valid end pulse. If the address is 0x40 to 0x46, the block raises `wr_strobe_o` for one cycle with `func_o` equal to address bits [2:0] and `value_o` equal to the value byte. Bits are taken most significant first, on rising bus clock edges.
- R3: If the address byte has bits [7:3] other than 01000 (any address outside 0x40 to 0x47), the transfer is ignored. No strobe is issued and `func_o` and `value_o` keep their values.
- R4: Only the last eight bits clocked before identity rises form the address. A 16-bit address phase uses its final byte. An idle gap between the address and value phases is allowed.
- R5: Only the last eight bits clocked during the value phase form the value byte when more than eight are sent.
- R6: An identity low pulse must last at least END_MIN_CYC+1 system cycles to end a transfer. A low pulse shorter than END_MIN_CYC cycles is ignored: nothing is committed, and the value phase continues shifting.
- R7: `wr_strobe_o` lasts exactly one cycle. `func_o` and `value_o` change only in the cycle the strobe is high.
- R8: Address 0x47 is a read. During its value phase, eight bits are returned most significant first, and the line is pulled low for each 0 bit. Bits 7 to 2 are 1 (released). Bit 1 is the level of `aux_in_n_i[1]` and bit 0 is the level of `aux_in_n_i[0]`. A read never produces a write strobe.
- R9: The auxiliary levels returned by a read are captured at the start of its value phase. Later changes on `aux_in_n_i` do not alter the returned bits.
- R10: `bus_data_oe_o` is asserted only during the value phase of a read and never while a write is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk_i | input | 1 | Bus clock from the controller, idle high |
| bus_id_i | input | 1 | Identity framing line, idle high |
| bus_data_i | input | 1 | Level of the shared data line |
| bus_data_oe_o | output | 1 | 1 pulls the shared data line low |
| aux_in_n_i | input | NUM_AUX | Active-low status inputs returned by a read |
| func_o | output | FUNC_W | Function index of the last committed write |
| value_o | output | BYTE_W | Value byte of the last committed write |
| wr_strobe_o | output | 1 | One-cycle commit strobe |

## Verification
The bench builds the block with END_MIN_CYC set to 40 instead of 600 and keeps the two-stage synchronizers and byte widths at their defaults. This brings both an accepted end pulse (48 cycles) and a rejected glitch (20 cycles) within a few hundred cycles per transfer. The bus runs with a 12-cycle half period, slow enough that the synchronizer latency never overlaps two bus edges. Under these values, over-long address and value phases, an idle gap between the phases, reads with changing status inputs and out-of-range addresses can all be run in one short simulation.

// File: rtl/idsel_pkg.sv
package idsel_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ADDR  = 2'd1,
      ST_VALUE = 2'd2,
      ST_END   = 2'd3
   } idsel_state_e;

endpackage

// File: rtl/idsel_sync.sv
module idsel_sync #(
   parameter int              WIDTH   = 1,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
      end else begin
         stg_q[0] <= d;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/idsel_pulse_timer.sv
module idsel_pulse_timer #(
   parameter int LIMIT = 600
)(
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);

   localparam int CNT_W = $clog2(LIMIT + 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt_q <= '0;
      else if (!run)                     cnt_q <= '0;
      else if (cnt_q != CNT_W'(LIMIT))   cnt_q <= cnt_q + 1'b1;
   end

   assign done = run && (cnt_q == CNT_W'(LIMIT - 1));

endmodule

// File: rtl/idsel_readback.sv
module idsel_readback #(
   parameter int BYTE_W  = 8,
   parameter int NUM_AUX = 2
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               shift,
   input  logic [NUM_AUX-1:0] aux_n,
   output logic               drive_low
);

   logic [BYTE_W-1:0] frame;
   logic [BYTE_W-1:0] sr_q;

   for (genvar b = 0; b < BYTE_W; b++) begin : g_frame
      if (b < NUM_AUX) begin : g_aux
         assign frame[b] = aux_n[b];
      end else begin : g_pad
         assign frame[b] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sr_q <= '1;
      else if (load)  sr_q <= frame;
      else if (shift) sr_q <= {sr_q[BYTE_W-2:0], 1'b1};
   end

   assign drive_low = ~sr_q[BYTE_W-1];

endmodule

// File: rtl/idsel_serial_slave.sv
module idsel_serial_slave
   import idsel_pkg::*;
#(
   parameter int               BYTE_W      = 8,
   parameter int               FUNC_W      = 3,
   parameter int               NUM_AUX     = 2,
   parameter int               SYNC_STAGES = 2,
   parameter int               END_MIN_CYC = 600,
   parameter logic [BYTE_W-1:0] DEV_BASE   = 8'h40,
   parameter int               READ_FUNC   = 7
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_clk_i,
   input  logic               bus_id_i,
   input  logic               bus_data_i,
   output logic               bus_data_oe_o,
   input  logic [NUM_AUX-1:0] aux_in_n_i,
   output logic [FUNC_W-1:0]  func_o,
   output logic [BYTE_W-1:0]  value_o,
   output logic               wr_strobe_o
);

   localparam int SYNC_W = NUM_AUX + 3;

   // elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (END_MIN_CYC < 2) begin : g_chk_end
      $error("END_MIN_CYC must be at least 2");
   end
   if (FUNC_W >= BYTE_W) begin : g_chk_func
      $error("FUNC_W must be smaller than BYTE_W");
   end
   if (NUM_AUX < 1 || NUM_AUX > BYTE_W) begin : g_chk_aux
      $error("NUM_AUX must lie between 1 and BYTE_W");
   end
   if (READ_FUNC >= (1 << FUNC_W)) begin : g_chk_read
      $error("READ_FUNC must fit in FUNC_W bits");
   end
   if (DEV_BASE[FUNC_W-1:0] != '0) begin : g_chk_base
      $error("DEV_BASE low function bits must be zero");
   end

   // bus line synchronizers
   logic [SYNC_W-1:0]  s_vec;
   logic               s_clk, s_id, s_data;
   logic [NUM_AUX-1:0] s_aux;

   idsel_sync #(
      .WIDTH   (SYNC_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ({SYNC_W{1'b1}})
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({aux_in_n_i, bus_data_i, bus_id_i, bus_clk_i}),
      .q     (s_vec)
   );

   assign s_clk  = s_vec[0];
   assign s_id   = s_vec[1];
   assign s_data = s_vec[2];
   assign s_aux  = s_vec[SYNC_W-1:3];

   // bus clock edge detection
   logic p_clk_q;
   logic clk_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) p_clk_q <= 1'b1;
      else        p_clk_q <= s_clk;
   end

   assign clk_rise = s_clk & ~p_clk_q;

   // framing state and shift register
   idsel_state_e      state_q;
   logic [BYTE_W-1:0] shift_q;
   logic [FUNC_W-1:0] cur_func_q;
   logic              addr_hit;
   logic              is_read;
   logic              rd_load;
   logic              rd_shift;
   logic              rd_drive_low;
   logic              end_run;
   logic              end_done;

   assign addr_hit = (shift_q[BYTE_W-1:FUNC_W] == DEV_BASE[BYTE_W-1:FUNC_W]);
   assign is_read  = (cur_func_q == FUNC_W'(READ_FUNC));
   assign rd_load  = (state_q == ST_ADDR) && s_id && addr_hit &&
                     (shift_q[FUNC_W-1:0] == FUNC_W'(READ_FUNC));
   assign rd_shift = (state_q == ST_VALUE) && clk_rise;
   assign end_run  = (state_q == ST_END) && !s_id;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
      end else if (clk_rise && (state_q == ST_ADDR || state_q == ST_VALUE)) begin
         shift_q <= {shift_q[BYTE_W-2:0], s_data};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         cur_func_q  <= '0;
         func_o      <= '0;
         value_o     <= '0;
         wr_strobe_o <= 1'b0;
      end else begin
         wr_strobe_o <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (!s_id && !s_clk) state_q <= ST_ADDR;
            end
            ST_ADDR: begin
               if (s_id) begin
                  if (addr_hit) begin
                     state_q    <= ST_VALUE;
                     cur_func_q <= shift_q[FUNC_W-1:0];
                  end else begin
                     state_q    <= ST_IDLE;
                  end
               end
            end
            ST_VALUE: begin
               if (!s_id) state_q <= ST_END;
            end
            ST_END: begin
               if (s_id) begin
                  state_q <= ST_VALUE;
               end else if (end_done) begin
                  state_q <= ST_IDLE;
                  if (!is_read) begin
                     func_o      <= cur_func_q;
                     value_o     <= shift_q;
                     wr_strobe_o <= 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // end pulse width measurement
   idsel_pulse_timer #(
      .LIMIT (END_MIN_CYC)
   ) i_end_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (end_run),
      .done  (end_done)
   );

   // read-back of auxiliary inputs
   idsel_readback #(
      .BYTE_W  (BYTE_W),
      .NUM_AUX (NUM_AUX)
   ) i_readback (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (rd_load),
      .shift     (rd_shift),
      .aux_n     (s_aux),
      .drive_low (rd_drive_low)
   );

   assign bus_data_oe_o = (state_q == ST_VALUE) && is_read && rd_drive_low;

endmodule

// File: rtl/idsel_serial_slave_chk.sv
module idsel_serial_slave_chk #(
   parameter int BYTE_W      = 8,
   parameter int FUNC_W      = 3,
   parameter int END_MIN_CYC = 600,
   parameter int READ_FUNC   = 7
)(
   input logic              clk,
   input logic              rst_n,
   input logic              bus_id_i,
   input logic              bus_data_oe_o,
   input logic [FUNC_W-1:0] func_o,
   input logic [BYTE_W-1:0] value_o,
   input logic              wr_strobe_o
);

   localparam int LOW_W = $clog2(END_MIN_CYC + 1);

   // consecutive raw identity-low cycles, saturating
   logic [LOW_W-1:0] id_low_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                id_low_q <= '0;
      else if (bus_id_i)                         id_low_q <= '0;
      else if (id_low_q != LOW_W'(END_MIN_CYC))  id_low_q <= id_low_q + 1'b1;
   end

   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe_o |=> !wr_strobe_o); // R7

   AST_OUTPUTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_strobe_o |=> (wr_strobe_o || ($stable(func_o) && $stable(value_o)))); // R7

   AST_NO_READ_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe_o |-> (func_o != FUNC_W'(READ_FUNC))); // R8

   AST_LONG_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe_o |-> (id_low_q == LOW_W'(END_MIN_CYC))); // R6

   AST_DRIVE_WHILE_ID_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_data_oe_o) |-> bus_id_i); // R10

   AST_QUIET_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe_o |-> !bus_data_oe_o); // R10

endmodule

bind idsel_serial_slave idsel_serial_slave_chk #(
   .BYTE_W      (BYTE_W),
   .FUNC_W      (FUNC_W),
   .END_MIN_CYC (END_MIN_CYC),
   .READ_FUNC   (READ_FUNC)
) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bus_id_i      (bus_id_i),
   .bus_data_oe_o (bus_data_oe_o),
   .func_o        (func_o),
   .value_o       (value_o),
   .wr_strobe_o   (wr_strobe_o)
);

// File: tb/test_idsel_serial_slave.sv
`timescale 1ns/1ps
module test_idsel_serial_slave;

   localparam int END_CYC = 40;
   localparam int HALF    = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bclk = 1'b1;
   logic       bid = 1'b1;
   logic       bdata = 1'b1;
   logic [1:0] aux_n = 2'b11;
   logic       oe;
   logic [2:0] func;
   logic [7:0] value;
   logic       strobe;
   wire        line_w = bdata & ~oe;

   always #2.5 clk = ~clk;

   idsel_serial_slave #(
      .END_MIN_CYC (END_CYC)
   ) i_idsel_serial_slave (
      .clk           (clk),
      .rst_n         (rst_n),
      .bus_clk_i     (bclk),
      .bus_id_i      (bid),
      .bus_data_i    (line_w),
      .bus_data_oe_o (oe),
      .aux_in_n_i    (aux_n),
      .func_o        (func),
      .value_o       (value),
      .wr_strobe_o   (strobe)
   );

   int          checks = 0;
   int          errors = 0;
   int          stray_oe = 0;
   int          double_strobe = 0;
   bit          in_read = 1'b0;
   bit          done_flag = 1'b0;
   bit          prev_strobe = 1'b0;
   logic [10:0] exp_q[$];

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check_eq(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic send_bits(input logic [15:0] bits, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         bclk  = 1'b0;
         bdata = bits[i];
         tick(HALF);
         bclk  = 1'b1;
         tick(HALF);
      end
      bdata = 1'b1;
   endtask

   task automatic addr_phase(input logic [15:0] a, input int n);
      bid  = 1'b0;
      bclk = 1'b0;
      tick(HALF);
      send_bits(a, n);
      bid = 1'b1;
      tick(HALF);
   endtask

   task automatic end_pulse(input int w);
      bid = 1'b0;
      tick(w);
      bid = 1'b1;
      tick(2 * HALF);
   endtask

   task automatic write_xfer(input logic [7:0] a, input logic [7:0] v);
      exp_q.push_back({a[2:0], v});
      addr_phase({8'h00, a}, 8);
      send_bits({8'h00, v}, 8);
      end_pulse(END_CYC + 8);
   endtask

   task automatic ignored_xfer(input logic [7:0] a, input logic [7:0] v);
      addr_phase({8'h00, a}, 8);
      send_bits({8'h00, v}, 8);
      end_pulse(END_CYC + 8);
   endtask

   task automatic read_bits(output logic [7:0] r);
      for (int i = 7; i >= 0; i--) begin
         bclk  = 1'b0;
         bdata = 1'b1;
         tick(HALF);
         r[i]  = line_w;
         bclk  = 1'b1;
         tick(HALF);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (oe && !in_read) stray_oe++;
         if (strobe && prev_strobe) double_strobe++;
         prev_strobe = strobe;
         if (strobe) begin
            checks++;
            if (exp_q.size() == 0) begin
               errors++;
               $display("FAIL R3/R6/R8 unexpected strobe: actual %0h expected none",
                        {func, value});
            end else begin
               logic [10:0] e;
               e = exp_q.pop_front();
               if ({func, value} !== e) begin
                  errors++;
                  $display("FAIL R2 commit: actual %0h expected %0h", {func, value}, e);
               end
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] rd;
      tick(8);
      rst_n = 1'b1;
      tick(5);

      // R1 reset state
      check_eq("R1 strobe", int'(strobe), 0);
      check_eq("R1 func", int'(func), 0);
      check_eq("R1 value", int'(value), 0);
      check_eq("R1 oe", int'(oe), 0);

      // R2 plain writes
      write_xfer(8'h41, 8'hA5);
      tick(50);
      check_eq("R7 func hold", int'(func), 1);
      check_eq("R7 value hold", int'(value), 8'hA5);
      write_xfer(8'h46, 8'h3C);
      write_xfer(8'h40, 8'h00);
      write_xfer(8'h45, 8'hFF);
      check_eq("R2 queue drained", exp_q.size(), 0);

      // R3 out-of-range addresses
      ignored_xfer(8'h48, 8'h77);
      ignored_xfer(8'h3F, 8'h11);
      ignored_xfer(8'hC1, 8'h22);
      check_eq("R3 func unchanged", int'(func), 5);
      check_eq("R3 value unchanged", int'(value), 8'hFF);

      // R4 sixteen-bit address phase, last byte counts
      exp_q.push_back({3'd3, 8'h96});
      addr_phase(16'h1243, 16);
      send_bits(16'h0096, 8);
      end_pulse(END_CYC + 8);

      // R4 split transmission with idle gap
      exp_q.push_back({3'd2, 8'h5B});
      addr_phase(16'h0042, 8);
      tick(200);
      send_bits(16'h005B, 8);
      end_pulse(END_CYC + 8);

      // R5 over-long value phase
      exp_q.push_back({3'd4, 8'h69});
      addr_phase(16'h0044, 8);
      send_bits(16'h0F69, 12);
      end_pulse(END_CYC + 8);
      check_eq("R5 value", int'(value), 8'h69);

      // R6 short glitch ignored, value phase continues
      exp_q.push_back({3'd6, 8'hC3});
      addr_phase(16'h0046, 8);
      send_bits(16'h0081, 8);
      end_pulse(END_CYC / 2);
      check_eq("R6 no commit on glitch", exp_q.size(), 1);
      check_eq("R6 value unchanged", int'(value), 8'h69);
      send_bits(16'h00C3, 8);
      end_pulse(END_CYC + 8);
      check_eq("R6 commit after long pulse", exp_q.size(), 0);

      // R8 reads
      aux_n   = 2'b10;
      tick(10);
      in_read = 1'b1;
      addr_phase(16'h0047, 8);
      read_bits(rd);
      tick(4);
      in_read = 1'b0;
      check_eq("R8 read aux 10", int'(rd), 8'hFE);
      end_pulse(END_CYC + 8);

      aux_n   = 2'b01;
      tick(10);
      in_read = 1'b1;
      addr_phase(16'h0047, 8);
      read_bits(rd);
      tick(4);
      in_read = 1'b0;
      check_eq("R8 read aux 01", int'(rd), 8'hFD);
      end_pulse(END_CYC + 8);
      check_eq("R8 func unchanged", int'(func), 6);
      check_eq("R8 value unchanged", int'(value), 8'hC3);
      check_eq("R10 released after read", int'(oe), 0);

      // R9 status captured at value phase start
      aux_n   = 2'b10;
      tick(10);
      in_read = 1'b1;
      addr_phase(16'h0047, 8);
      aux_n   = 2'b01;
      read_bits(rd);
      tick(4);
      in_read = 1'b0;
      check_eq("R9 captured aux", int'(rd), 8'hFE);
      end_pulse(END_CYC + 8);

      // final write after reads
      write_xfer(8'h43, 8'h5A);
      tick(20);

      check_eq("R2 all commits seen", exp_q.size(), 0);
      check_eq("R7 single-cycle strobe", double_strobe, 0);
      check_eq("R10 no drive outside read", stray_oe, 0);

      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule